// File: doc/BRIEF.md
# Result Writeback Placement Controller

This block sits after the execution units of a per-warp operand bypass scheme. It decides where each finished result is stored: in the small bypass buffer that lets nearby instructions reuse values without a register file read, in the register file, or in both. It also tracks a sliding window of the most recent results. When a buffered result that still owes a register file write leaves that window, the block issues a deferred register file write for it. If a newer result for the same register has arrived in the meantime, that deferred write is dropped. Repeated updates to one register therefore cost a single register file write, or none.

Each result arrives with a two-bit placement hint. A mode input, sampled with every accepted result, selects one of three policies: write-through, plain write-back that ignores the hints, and hint-guided write-back. Buffer write commands leave on a registered strobe. Register file writes leave through a ready/valid port. Results are accepted on a ready/valid port that holds off new results while register file writes are still pending, so no deferred write is ever lost.

Top module: `wb_steer`

## Requirements
- R1: While reset is held, `rf_wr_valid` and `buf_wr_en` are low and `res_ready` is high.
- R2: Mode encoding: 0 = write-through, 1 = plain write-back, 2 = hint-guided, 3 = write-through. In write-through, each accepted result produces a buffer write command in the cycle after acceptance, carrying its register and data, and it also queues one register file write.
- R3: In plain write-back mode, each result goes to the buffer only and is marked dirty. When it leaves the window it is written to the register file only if none of the next WIN accepted results, WIN being the window depth (default 3), targets the same register. Three consecutive results to one register therefore yield one register file write.
- R4: Hint bit 1 enables the buffer and hint bit 0 enables the register file. In hint-guided mode, hint 01 queues an immediate register file write and produces no buffer write command.
- R5: In hint-guided mode, hint 10 produces a buffer write command and never produces a register file write.
- R6: In hint-guided mode, hint 11 produces a buffer write command and a deferred register file write under the same leave-the-window and supersede rule as R3.
- R7: In hint-guided mode, hint 00 produces neither a buffer command nor a register file write.
- R8: Register file writes leave in acceptance order. When one accepted result both pushes an older entry out of the window and needs an immediate write, the deferred write of the departing entry goes first.
- R9: `res_ready` is high exactly when no register file write is pending, or when exactly one is pending and `rf_wr_ready` is high. While `rf_wr_valid` is high and `rf_wr_ready` is low, the request stays valid with unchanged register and data. Every queued write is eventually presented.
- R10: For the destination sequence r1,r1,r1,r2,r3,r2,r4,r5,r4,r5, the sequence registers receive this many register file writes once the sequence has left the window: 10 in write-through, 5 in plain write-back, and 2 in hint-guided mode. The hint-guided count uses hint 11 on the third result, hint 01 on the ninth and hint 10 on all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Placement policy, sampled with each accepted result |
| res_valid | input | 1 | A result is offered |
| res_ready | output | 1 | The controller takes the offered result at this edge |
| res_reg | input | REG_W | Destination register of the result |
| res_data | input | DATA_W | Result value |
| res_hint | input | 2 | Placement hint: bit 1 = buffer, bit 0 = register file |
| buf_wr_en | output | 1 | Buffer write command strobe |
| buf_wr_reg | output | REG_W | Register tag for the buffer write |
| buf_wr_data | output | DATA_W | Value for the buffer write |
| rf_wr_valid | output | 1 | Register file write request |
| rf_wr_ready | input | 1 | Register file accepts the write |
| rf_wr_reg | output | REG_W | Register file write address |
| rf_wr_data | output | DATA_W | Register file write value |

## Verification
A wrong dirty flag or a missed supersede shows up at the register file port as an extra, missing or stale write. This happens no later than WIN accepted results after the faulty entry was written, when that entry leaves the window. A fault in the pending-write queue becomes visible at the very next handshake: the written register or data is wrong, or `res_ready` differs from the pending count. A wrong placement decision shows in the buffer strobe one cycle after acceptance. The bench keeps a behavioural model of the window and of the pending writes. Each clock it compares every buffer command, every accepted register file write and `res_ready` against that model, and it also checks the totals for the fixed sequence of R10.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    PL_THRU = 2'd0,
    PL_BACK = 2'd1,
    PL_HINT = 2'd2,
    PL_ALT  = 2'd3
  } place_mode_e;

  typedef struct packed {
    logic to_buf;   // value lands in the bypass buffer
    logic rf_now;   // immediate register file write
    logic defer;    // owes a register file write when it leaves the window
  } route_t;
endpackage

// File: rtl/wbc_route.sv
module wbc_route
  import wbc_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] hint,
  output route_t     route
);
  always_comb begin
    unique case (place_mode_e'(mode))
      PL_BACK: route = '{to_buf: 1'b1, rf_now: 1'b0, defer: 1'b1};
      PL_HINT: route = '{to_buf: hint[1],
                         rf_now: hint[0] & ~hint[1],
                         defer:  hint[0] & hint[1]};
      default: route = '{to_buf: 1'b1, rf_now: 1'b1, defer: 1'b0};
    endcase
  end
endmodule

// File: rtl/wbc_window.sv
// Sliding window of the last WIN accepted results (WIN >= 2).
// Slot 0 is the youngest entry, slot WIN-1 the oldest.
module wbc_window #(
  parameter int WIN    = 3,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              push_keep,   // the arriving result is stored somewhere
  input  logic              push_dirty,  // the arriving result owes a deferred write
  input  logic [REG_W-1:0]  push_reg,
  input  logic [DATA_W-1:0] push_data,
  output logic              ev_valid,
  output logic [REG_W-1:0]  ev_reg,
  output logic [DATA_W-1:0] ev_data
);
  localparam int LAST = WIN - 1;

  logic [WIN-1:0]    vld;
  logic [WIN-1:0]    dirty;
  logic [WIN-1:0]    hit;
  logic [REG_W-1:0]  regs [WIN];
  logic [DATA_W-1:0] vals [WIN];

  // A newer stored write to the same register supersedes the older entry.
  always_comb begin
    for (int i = 0; i < WIN; i++) begin
      hit[i] = push_keep && (regs[i] == push_reg);
    end
  end

  assign ev_valid = push && vld[LAST] && dirty[LAST] && !hit[LAST];
  assign ev_reg   = regs[LAST];
  assign ev_data  = vals[LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      dirty <= '0;
    end else if (push) begin
      vld[0]   <= 1'b1;
      dirty[0] <= push_dirty;
      for (int i = 1; i < WIN; i++) begin
        vld[i]   <= vld[i-1];
        dirty[i] <= dirty[i-1] & ~hit[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      regs[0] <= push_reg;
      vals[0] <= push_data;
      for (int i = 1; i < WIN; i++) begin
        regs[i] <= regs[i-1];
        vals[i] <= vals[i-1];
      end
    end
  end
endmodule

// File: rtl/wbc_rfq.sv
// Two-entry ordered queue in front of the register file write port.
// Entry A (deferred) is placed ahead of entry B (immediate).
module wbc_rfq #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_a,
  input  logic [REG_W-1:0]  a_reg,
  input  logic [DATA_W-1:0] a_data,
  input  logic              push_b,
  input  logic [REG_W-1:0]  b_reg,
  input  logic [DATA_W-1:0] b_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [REG_W-1:0]  out_reg,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        fill
);
  logic [1:0]        cnt, n_cnt;
  logic [REG_W-1:0]  r0, r1, n_r0, n_r1;
  logic [DATA_W-1:0] d0, d1, n_d0, n_d1;
  logic              pop;

  assign pop = (cnt != 2'd0) && out_ready;

  always_comb begin
    n_r0  = r0;
    n_d0  = d0;
    n_r1  = r1;
    n_d1  = d1;
    n_cnt = cnt;
    if (pop) begin
      n_r0  = r1;
      n_d0  = d1;
      n_cnt = cnt - 2'd1;
    end
    if (push_a) begin
      if (n_cnt == 2'd0) begin
        n_r0 = a_reg;
        n_d0 = a_data;
      end else begin
        n_r1 = a_reg;
        n_d1 = a_data;
      end
      n_cnt = n_cnt + 2'd1;
    end
    if (push_b) begin
      if (n_cnt == 2'd0) begin
        n_r0 = b_reg;
        n_d0 = b_data;
      end else begin
        n_r1 = b_reg;
        n_d1 = b_data;
      end
      n_cnt = n_cnt + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= 2'd0;
    else     cnt <= n_cnt;
  end

  always_ff @(posedge clk) begin
    r0 <= n_r0;
    d0 <= n_d0;
    r1 <= n_r1;
    d1 <= n_d1;
  end

  assign out_valid = (cnt != 2'd0);
  assign out_reg   = r0;
  assign out_data  = d0;
  assign fill      = cnt;
endmodule

// File: rtl/wb_steer.sv
module wb_steer
  import wbc_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int WIN      = 3,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [REG_W-1:0]  res_reg,
  input  logic [DATA_W-1:0] res_data,
  input  logic [1:0]        res_hint,
  output logic              buf_wr_en,
  output logic [REG_W-1:0]  buf_wr_reg,
  output logic [DATA_W-1:0] buf_wr_data,
  output logic              rf_wr_valid,
  input  logic              rf_wr_ready,
  output logic [REG_W-1:0]  rf_wr_reg,
  output logic [DATA_W-1:0] rf_wr_data
);
  route_t            route;
  logic              accept;
  logic              ev_valid;
  logic [REG_W-1:0]  ev_reg;
  logic [DATA_W-1:0] ev_data;
  logic [1:0]        fill;

  wbc_route u_route (
    .mode  (mode),
    .hint  (res_hint),
    .route (route)
  );

  // At most two writes can be queued per accepted result, so hold off
  // new results until the queue is sure to have room for both.
  assign res_ready = (fill == 2'd0) || ((fill == 2'd1) && rf_wr_ready);
  assign accept    = res_valid && res_ready;

  wbc_window #(.WIN(WIN), .REG_W(REG_W), .DATA_W(DATA_W)) u_win (
    .clk        (clk),
    .rst        (rst),
    .push       (accept),
    .push_keep  (route.to_buf | route.rf_now),
    .push_dirty (route.defer),
    .push_reg   (res_reg),
    .push_data  (res_data),
    .ev_valid   (ev_valid),
    .ev_reg     (ev_reg),
    .ev_data    (ev_data)
  );

  wbc_rfq #(.REG_W(REG_W), .DATA_W(DATA_W)) u_rfq (
    .clk       (clk),
    .rst       (rst),
    .push_a    (ev_valid),
    .a_reg     (ev_reg),
    .a_data    (ev_data),
    .push_b    (accept && route.rf_now),
    .b_reg     (res_reg),
    .b_data    (res_data),
    .out_ready (rf_wr_ready),
    .out_valid (rf_wr_valid),
    .out_reg   (rf_wr_reg),
    .out_data  (rf_wr_data),
    .fill      (fill)
  );

  always_ff @(posedge clk) begin
    if (rst) buf_wr_en <= 1'b0;
    else     buf_wr_en <= accept && route.to_buf;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      buf_wr_reg  <= res_reg;
      buf_wr_data <= res_data;
    end
  end
endmodule

// File: rtl/wb_steer_chk.sv
module wb_steer_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              res_valid,
  input logic              res_ready,
  input logic [1:0]        res_hint,
  input logic              buf_wr_en,
  input logic              rf_wr_valid,
  input logic              rf_wr_ready,
  input logic [REG_W-1:0]  rf_wr_reg,
  input logic [DATA_W-1:0] rf_wr_data
);
  logic take;
  assign take = res_valid && res_ready;

  // R9
  rf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rf_wr_valid && !rf_wr_ready |=> rf_wr_valid && $stable(rf_wr_reg) && $stable(rf_wr_data));

  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !rf_wr_valid |-> res_ready);

  // R2
  thru_both_chk: assert property (@(posedge clk) disable iff (rst)
    take && (mode == 2'd0 || mode == 2'd3) |=> buf_wr_en && rf_wr_valid);

  // R4
  rf_only_chk: assert property (@(posedge clk) disable iff (rst)
    take && mode == 2'd2 && res_hint == 2'b01 |=> !buf_wr_en && rf_wr_valid);

  // R5
  transient_buf_chk: assert property (@(posedge clk) disable iff (rst)
    take && mode == 2'd2 && res_hint == 2'b10 |=> buf_wr_en);

  // R7
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    take && mode == 2'd2 && res_hint == 2'b00 |=> !buf_wr_en);
endmodule

bind wb_steer wb_steer_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .mode        (mode),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_hint    (res_hint),
  .buf_wr_en   (buf_wr_en),
  .rf_wr_valid (rf_wr_valid),
  .rf_wr_ready (rf_wr_ready),
  .rf_wr_reg   (rf_wr_reg),
  .rf_wr_data  (rf_wr_data)
);

// File: tb/wb_steer_tb_top.sv
module wb_steer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 3;
  localparam logic [4:0] PAD = 5'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [4:0]  res_reg = '0;
  logic [31:0] res_data = '0;
  logic [1:0]  res_hint = '0;
  logic        buf_wr_en;
  logic [4:0]  buf_wr_reg;
  logic [31:0] buf_wr_data;
  logic        rf_wr_valid;
  logic        rf_wr_ready = 1'b1;
  logic [4:0]  rf_wr_reg;
  logic [31:0] rf_wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_steer #(.NUM_REGS(32), .DATA_W(32), .WIN(WIN)) dut_i (
    .clk(clk), .rst(rst), .mode(mode),
    .res_valid(res_valid), .res_ready(res_ready), .res_reg(res_reg),
    .res_data(res_data), .res_hint(res_hint),
    .buf_wr_en(buf_wr_en), .buf_wr_reg(buf_wr_reg), .buf_wr_data(buf_wr_data),
    .rf_wr_valid(rf_wr_valid), .rf_wr_ready(rf_wr_ready),
    .rf_wr_reg(rf_wr_reg), .rf_wr_data(rf_wr_data)
  );

  typedef struct { logic [4:0] r; logic [31:0] d; bit dirty; } ent_t;
  typedef struct { logic [4:0] r; logic [31:0] d; int tag; } wr_t;

  ent_t win_q[$];
  wr_t  exp_q[$];
  int   errs = 0, checks = 0, nwr = 0, bp = 0;
  bit   run = 0, done = 0;
  bit   eb_en = 0;
  logic [4:0]  eb_r;
  logic [31:0] eb_d;
  int   eb_tag = 2;

  function automatic string tn(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural model of one accepted result.
  task automatic model_accept();
    bit to_buf, rf_now, defer, keep, both;
    int rtag;
    case (mode)
      2'd1: begin to_buf = 1; rf_now = 0; defer = 1; rtag = 3; end
      2'd2: begin
        to_buf = res_hint[1];
        rf_now = res_hint == 2'b01;
        defer  = res_hint == 2'b11;
        rtag   = (res_hint == 2'b01) ? 4 : (res_hint == 2'b10) ? 5 :
                 (res_hint == 2'b11) ? 6 : 7;
      end
      default: begin to_buf = 1; rf_now = 1; defer = 0; rtag = 2; end
    endcase
    keep = to_buf || rf_now;
    both = 0;
    if (win_q.size() == WIN) begin
      ent_t o;
      o = win_q.pop_front();
      if (o.dirty && !(keep && o.r == res_reg)) begin
        exp_q.push_back('{r: o.r, d: o.d, tag: (mode == 2'd1) ? 3 : 6});
        both = 1;
      end
    end
    foreach (win_q[i]) if (keep && win_q[i].r == res_reg) win_q[i].dirty = 0;
    win_q.push_back('{r: res_reg, d: res_data, dirty: defer});
    if (rf_now) exp_q.push_back('{r: res_reg, d: res_data, tag: both ? 8 : rtag});
    eb_en = to_buf; eb_r = res_reg; eb_d = res_data; eb_tag = rtag;
  endtask

  always @(negedge clk) begin
    if (!rst && run) begin
      int sz;
      sz = exp_q.size();
      chk(buf_wr_en == eb_en, tn(eb_tag), "buf_wr_en", buf_wr_en, eb_en);
      if (eb_en && buf_wr_en)
        chk(buf_wr_reg == eb_r && buf_wr_data == eb_d, tn(eb_tag), "buf payload",
            {buf_wr_reg, buf_wr_data}, {eb_r, eb_d});
      chk(res_ready == (sz == 0 || (sz == 1 && rf_wr_ready)), "R9", "res_ready",
          res_ready, (sz == 0 || (sz == 1 && rf_wr_ready)));
      chk(rf_wr_valid == (sz != 0), "R9", "rf_wr_valid vs pending", rf_wr_valid, sz != 0);
      if (rf_wr_valid && rf_wr_ready && sz != 0) begin
        wr_t h;
        h = exp_q.pop_front();
        chk(rf_wr_reg == h.r && rf_wr_data == h.d, tn(h.tag), "rf write",
            {rf_wr_reg, rf_wr_data}, {h.r, h.d});
        if (rf_wr_reg != PAD) nwr++;
      end
      eb_en = 0;
      if (res_valid && res_ready) model_accept();
    end
  end

  // Register file backpressure driver.
  initial begin
    forever begin
      @(posedge clk); #1;
      rf_wr_ready = (bp == 0) ? 1'b1 : ($urandom % 3 != 0);
    end
  end

  task automatic send(input logic [1:0] m, input logic [4:0] r,
                      input logic [31:0] d, input logic [1:0] h);
    mode = m; res_reg = r; res_data = d; res_hint = h; res_valid = 1'b1;
    do @(negedge clk); while (!res_ready);
    @(posedge clk); #1;
    res_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  // R10 reference sequence with WIN padding results afterwards.
  task automatic ref_seq(input logic [1:0] m, input int want);
    logic [4:0] seq [10] = '{5'd1, 5'd1, 5'd1, 5'd2, 5'd3, 5'd2, 5'd4, 5'd5, 5'd4, 5'd5};
    nwr = 0;
    for (int i = 0; i < 10; i++)
      send(m, seq[i], 32'hA000 + i + 32'(m) * 32'h100,
           (i == 2) ? 2'b11 : (i == 8) ? 2'b01 : 2'b10);
    for (int i = 0; i < WIN; i++) send(m, PAD, 32'hF000 + i, 2'b10);
    drain();
    chk(nwr == want, "R10", "rf write count", nwr, want);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rf_wr_valid == 1'b0, "R1", "rf_wr_valid in reset", rf_wr_valid, 0);
    chk(buf_wr_en == 1'b0, "R1", "buf_wr_en in reset", buf_wr_en, 0);
    chk(res_ready == 1'b1, "R1", "res_ready in reset", res_ready, 1);
    rst = 1'b0;
    run = 1'b1;
    @(posedge clk); #1;
    ref_seq(2'd0, 10);   // R2 write-through
    ref_seq(2'd1, 5);    // R3 plain write-back
    ref_seq(2'd2, 2);    // R4 R5 R6 hint-guided
    // R7 dropped results and R2 alternate write-through encoding
    send(2'd2, 5'd9, 32'h1111, 2'b00);
    send(2'd2, 5'd9, 32'h2222, 2'b00);
    send(2'd3, 5'd10, 32'h3333, 2'b00);
    send(2'd2, 5'd11, 32'h4444, 2'b11);
    for (int i = 0; i < WIN; i++) send(2'd1, PAD, 32'h5555 + i, 2'b10);
    drain();
    // R8 R9 random traffic under backpressure
    bp = 1;
    for (int i = 0; i < 400; i++)
      send(2'($urandom % 4), 5'($urandom % 8), $urandom, 2'($urandom % 4));
    bp = 0;
    drain();
    chk(exp_q.size() == 0, "R9", "writes left pending", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R9 watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule